// File: doc/BRIEF.md
# External Register Access Bridge

This block joins the decoded request of a CPU-side register file to the port of one register whose storage lives outside the register file. It forwards four things to the external register: a per-sub-word request strobe, a write flag, write data and active-high bit enables. In the other direction it returns the external register's read data, read acknowledgement and write acknowledgement to the response path. It also raises a flag that tells the response path the current transfer is served externally, so the response path waits for an acknowledgement instead of answering by itself.

A register may be wider than the CPU data bus. In that case it is split into sub-words, and each sub-word gets its own strobe bit. Some registers can only be read by software and some can only be written. For these, the bridge suppresses the strobe for the unused direction, holds the unused outputs at zero and ignores the unused acknowledgements. A read of a write-only register therefore never waits for an acknowledgement: the response path completes it with zero data. A configuration that is neither readable nor writable stops elaboration with an error. A parameter chooses whether the outgoing request passes straight through or goes through a stage of flops.

Top module: `ext_reg_bridge`

## Requirements
- R1: The number of sub-words, SUBW, is REG_W/BUS_W when REG_W exceeds BUS_W, and 1 otherwise. Bit i of `ext_req` is the strobe for sub-word i and follows bit i of `dec_strb`.
- R2: When the register is not software-writable, `ext_req` stays all-zero during write transfers (`dec_is_wr`=1).
- R3: When the register is not software-readable, `ext_req` stays all-zero during read transfers (`dec_is_wr`=0).
- R4: `ext_wr_data` and `ext_wr_biten` are BUS_W bits wide. For a writable register they carry `dec_wr_data` and `dec_wr_biten` unchanged, with a biten bit of 1 meaning that bit may change. For a register that is not writable they stay zero.
- R5: `is_external` is high in the same cycle as any `dec_strb` bit. The flag is additionally qualified by direction: only on reads for a read-only register, and only on writes for a write-only register.
- R6: `rsp_rd_ack` and `rsp_rd_data` follow `ext_rd_ack` and `ext_rd_data` only for a readable register. Otherwise they stay zero, so a read of a write-only register returns zero data.
- R7: `rsp_wr_ack` follows `ext_wr_ack` only for a writable register. Otherwise it stays zero.
- R8: With REGISTERED=1, `ext_req`, `ext_req_is_wr`, `ext_wr_data` and `ext_wr_biten` are zero while `rst_n` is low. After reset they show the decoded request one clock after it is presented.
- R9: With REGISTERED=0, the same outputs follow the decoded request in the same cycle, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_strb | input | SUBW | Decoded access strobe, one bit per sub-word |
| dec_is_wr | input | 1 | Decoded transfer is a write |
| dec_wr_data | input | BUS_W | Decoded write data |
| dec_wr_biten | input | BUS_W | Decoded bit enables, active high |
| ext_req | output | SUBW | Request strobe to the external register |
| ext_req_is_wr | output | 1 | Write flag to the external register |
| ext_wr_data | output | BUS_W | Write data to the external register |
| ext_wr_biten | output | BUS_W | Bit enables to the external register |
| ext_rd_ack | input | 1 | Read acknowledgement from the external register |
| ext_rd_data | input | BUS_W | Read data from the external register |
| ext_wr_ack | input | 1 | Write acknowledgement from the external register |
| is_external | output | 1 | Current decoded transfer is served externally |
| rsp_rd_ack | output | 1 | Read acknowledgement toward the response path |
| rsp_rd_data | output | BUS_W | Read data toward the response path |
| rsp_wr_ack | output | 1 | Write acknowledgement toward the response path |

## Verification
In registered mode, the acknowledgement for one request can come back in the same cycle that the next decoded request arrives. The forward path and the return path then act together. The bench provokes this by driving a fresh strobe while it raises the external acknowledgements and read data. It then checks two things: the return outputs follow the gated acknowledgements in that same cycle, and the new strobe appears at `ext_req` one clock later, undisturbed. The same stimulus goes to read-only and write-only instances, so each direction gate is judged against an ungated neighbour.

// File: rtl/ebr_pkg.sv
package ebr_pkg;

    typedef enum logic [1:0] {
        ACC_RW   = 2'd0,
        ACC_RO   = 2'd1,
        ACC_WO   = 2'd2,
        ACC_NONE = 2'd3
    } acc_kind_e;

    function automatic acc_kind_e acc_kind(input bit rd_ok, input bit wr_ok);
        if (rd_ok && wr_ok) return ACC_RW;
        if (rd_ok)          return ACC_RO;
        if (wr_ok)          return ACC_WO;
        return ACC_NONE;
    endfunction

    function automatic int subword_count(input int reg_w, input int bus_w);
        return (reg_w > bus_w) ? (reg_w / bus_w) : 1;
    endfunction

endpackage

// File: rtl/ebr_req_gate.sv
module ebr_req_gate
    import ebr_pkg::*;
#(
    parameter int SUBW        = 2,
    parameter bit SW_READABLE = 1'b1,
    parameter bit SW_WRITABLE = 1'b1
) (
    input  logic [SUBW-1:0] dec_strb,
    input  logic            dec_is_wr,
    output logic [SUBW-1:0] gated_strb,
    output logic            is_external
);
    localparam acc_kind_e KIND = acc_kind(SW_READABLE, SW_WRITABLE);

    logic dir_ok;

    generate
        if (KIND == ACC_RW) begin : g_rw
            assign dir_ok = 1'b1;
        end else if (KIND == ACC_RO) begin : g_ro
            assign dir_ok = ~dec_is_wr;
        end else if (KIND == ACC_WO) begin : g_wo
            assign dir_ok = dec_is_wr;
        end else begin : g_none
            $error("ebr_req_gate: register has no readable and no writable fields");
            assign dir_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < SUBW; i++) begin
            gated_strb[i] = dec_strb[i] & dir_ok;
        end
        is_external = (|dec_strb) & dir_ok;
    end
endmodule

// File: rtl/ebr_req_stage.sv
module ebr_req_stage #(
    parameter int SUBW        = 2,
    parameter int BUS_W       = 32,
    parameter bit REGISTERED  = 1'b1,
    parameter bit SW_WRITABLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUBW-1:0]  req_in,
    input  logic             is_wr_in,
    input  logic [BUS_W-1:0] wdata_in,
    input  logic [BUS_W-1:0] biten_in,
    output logic [SUBW-1:0]  req_out,
    output logic             is_wr_out,
    output logic [BUS_W-1:0] wdata_out,
    output logic [BUS_W-1:0] biten_out
);
    typedef struct packed {
        logic [SUBW-1:0]  req;
        logic             is_wr;
        logic [BUS_W-1:0] wdata;
        logic [BUS_W-1:0] biten;
    } stage_t;

    stage_t st_d;
    stage_t st_q;

    always_comb begin
        st_d       = '0;
        st_d.req   = req_in;
        st_d.is_wr = is_wr_in;
        if (SW_WRITABLE) begin
            st_d.wdata = wdata_in;
            st_d.biten = biten_in;
        end
    end

    generate
        if (REGISTERED) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end else begin : g_comb
            always_comb st_q = st_d;
        end
    endgenerate

    assign req_out   = st_q.req;
    assign is_wr_out = st_q.is_wr;
    assign wdata_out = st_q.wdata;
    assign biten_out = st_q.biten;
endmodule

// File: rtl/ebr_rsp_merge.sv
module ebr_rsp_merge #(
    parameter int BUS_W       = 32,
    parameter bit SW_READABLE = 1'b1,
    parameter bit SW_WRITABLE = 1'b1
) (
    input  logic             ext_rd_ack,
    input  logic [BUS_W-1:0] ext_rd_data,
    input  logic             ext_wr_ack,
    output logic             rsp_rd_ack,
    output logic [BUS_W-1:0] rsp_rd_data,
    output logic             rsp_wr_ack
);
    generate
        if (SW_READABLE) begin : g_rd
            assign rsp_rd_ack  = ext_rd_ack;
            assign rsp_rd_data = ext_rd_data;
        end else begin : g_no_rd
            assign rsp_rd_ack  = 1'b0;
            assign rsp_rd_data = '0;
        end
        if (SW_WRITABLE) begin : g_wr
            assign rsp_wr_ack = ext_wr_ack;
        end else begin : g_no_wr
            assign rsp_wr_ack = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/ext_reg_bridge.sv
module ext_reg_bridge
    import ebr_pkg::*;
#(
    parameter int BUS_W        = 32,
    parameter int REG_W        = 64,
    parameter bit SW_READABLE  = 1'b1,
    parameter bit SW_WRITABLE  = 1'b1,
    parameter bit REGISTERED   = 1'b1,
    localparam int SUBW        = subword_count(REG_W, BUS_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUBW-1:0]  dec_strb,
    input  logic             dec_is_wr,
    input  logic [BUS_W-1:0] dec_wr_data,
    input  logic [BUS_W-1:0] dec_wr_biten,
    output logic [SUBW-1:0]  ext_req,
    output logic             ext_req_is_wr,
    output logic [BUS_W-1:0] ext_wr_data,
    output logic [BUS_W-1:0] ext_wr_biten,
    input  logic             ext_rd_ack,
    input  logic [BUS_W-1:0] ext_rd_data,
    input  logic             ext_wr_ack,
    output logic             is_external,
    output logic             rsp_rd_ack,
    output logic [BUS_W-1:0] rsp_rd_data,
    output logic             rsp_wr_ack
);
    logic [SUBW-1:0] gated_strb;

    ebr_req_gate #(
        .SUBW        (SUBW),
        .SW_READABLE (SW_READABLE),
        .SW_WRITABLE (SW_WRITABLE)
    ) u_gate (
        .dec_strb    (dec_strb),
        .dec_is_wr   (dec_is_wr),
        .gated_strb  (gated_strb),
        .is_external (is_external)
    );

    ebr_req_stage #(
        .SUBW        (SUBW),
        .BUS_W       (BUS_W),
        .REGISTERED  (REGISTERED),
        .SW_WRITABLE (SW_WRITABLE)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_in    (gated_strb),
        .is_wr_in  (dec_is_wr),
        .wdata_in  (dec_wr_data),
        .biten_in  (dec_wr_biten),
        .req_out   (ext_req),
        .is_wr_out (ext_req_is_wr),
        .wdata_out (ext_wr_data),
        .biten_out (ext_wr_biten)
    );

    ebr_rsp_merge #(
        .BUS_W       (BUS_W),
        .SW_READABLE (SW_READABLE),
        .SW_WRITABLE (SW_WRITABLE)
    ) u_rsp (
        .ext_rd_ack  (ext_rd_ack),
        .ext_rd_data (ext_rd_data),
        .ext_wr_ack  (ext_wr_ack),
        .rsp_rd_ack  (rsp_rd_ack),
        .rsp_rd_data (rsp_rd_data),
        .rsp_wr_ack  (rsp_wr_ack)
    );
endmodule

// File: rtl/ebr_chk.sv
module ebr_chk #(
    parameter int SUBW        = 2,
    parameter int BUS_W       = 32,
    parameter bit SW_READABLE = 1'b1,
    parameter bit SW_WRITABLE = 1'b1,
    parameter bit REGISTERED  = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SUBW-1:0]  dec_strb,
    input logic             dec_is_wr,
    input logic [SUBW-1:0]  ext_req,
    input logic             ext_req_is_wr,
    input logic [BUS_W-1:0] ext_wr_biten,
    input logic             ext_rd_ack,
    input logic             ext_wr_ack,
    input logic             is_external,
    input logic             rsp_rd_ack,
    input logic             rsp_wr_ack
);
    localparam bit RW = SW_READABLE && SW_WRITABLE;

    AST_RO_NO_WR_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        (!SW_WRITABLE && ext_req_is_wr) |-> (ext_req == '0)); // R2

    AST_WO_NO_RD_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        (!SW_READABLE && !ext_req_is_wr) |-> (ext_req == '0)); // R3

    AST_NOWR_BITEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !SW_WRITABLE |-> (ext_wr_biten == '0)); // R4

    AST_EXT_NEEDS_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        is_external |-> (|dec_strb)); // R5

    AST_RD_ACK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rd_ack |-> ext_rd_ack); // R6

    AST_WR_ACK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_ack |-> ext_wr_ack); // R7

    AST_REG_REQ_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (REGISTERED && RW) |=> (ext_req == $past(dec_strb))); // R8

    AST_REG_WR_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        REGISTERED |=> (ext_req_is_wr == $past(dec_is_wr))); // R8

    AST_COMB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!REGISTERED && RW) |-> (ext_req == dec_strb)); // R9
endmodule

bind ext_reg_bridge ebr_chk #(
    .SUBW        (SUBW),
    .BUS_W       (BUS_W),
    .SW_READABLE (SW_READABLE),
    .SW_WRITABLE (SW_WRITABLE),
    .REGISTERED  (REGISTERED)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dec_strb      (dec_strb),
    .dec_is_wr     (dec_is_wr),
    .ext_req       (ext_req),
    .ext_req_is_wr (ext_req_is_wr),
    .ext_wr_biten  (ext_wr_biten),
    .ext_rd_ack    (ext_rd_ack),
    .ext_wr_ack    (ext_wr_ack),
    .is_external   (is_external),
    .rsp_rd_ack    (rsp_rd_ack),
    .rsp_wr_ack    (rsp_wr_ack)
);

// File: tb/sim_ext_reg_bridge.sv
module sim_ext_reg_bridge;
    localparam int BW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [1:0]    strb0, strb_wo;
    logic [0:0]    strb_ro;
    logic          is_wr;
    logic [BW-1:0] wd, be;
    logic          x_rd_ack, x_wr_ack;
    logic [BW-1:0] x_rd_data;

    logic [1:0] req0, req_wo;
    logic [0:0] req_ro;
    logic iw0, iw_ro, iw_wo;
    logic [BW-1:0] wd0, be0, wd_ro, be_ro, wd_wo, be_wo;
    logic ie0, ie_ro, ie_wo;
    logic ra0, ra_ro, ra_wo, wa0, wa_ro, wa_wo;
    logic [BW-1:0] rd0, rd_ro, rd_wo;

    int checks = 0;
    int errors = 0;

    ext_reg_bridge u0 (
        .clk(clk), .rst_n(rst_n), .dec_strb(strb0), .dec_is_wr(is_wr),
        .dec_wr_data(wd), .dec_wr_biten(be), .ext_req(req0), .ext_req_is_wr(iw0),
        .ext_wr_data(wd0), .ext_wr_biten(be0), .ext_rd_ack(x_rd_ack),
        .ext_rd_data(x_rd_data), .ext_wr_ack(x_wr_ack), .is_external(ie0),
        .rsp_rd_ack(ra0), .rsp_rd_data(rd0), .rsp_wr_ack(wa0));

    ext_reg_bridge #(.REG_W(32), .SW_WRITABLE(1'b0), .REGISTERED(1'b0)) u_ro (
        .clk(clk), .rst_n(rst_n), .dec_strb(strb_ro), .dec_is_wr(is_wr),
        .dec_wr_data(wd), .dec_wr_biten(be), .ext_req(req_ro), .ext_req_is_wr(iw_ro),
        .ext_wr_data(wd_ro), .ext_wr_biten(be_ro), .ext_rd_ack(x_rd_ack),
        .ext_rd_data(x_rd_data), .ext_wr_ack(x_wr_ack), .is_external(ie_ro),
        .rsp_rd_ack(ra_ro), .rsp_rd_data(rd_ro), .rsp_wr_ack(wa_ro));

    ext_reg_bridge #(.SW_READABLE(1'b0)) u_wo (
        .clk(clk), .rst_n(rst_n), .dec_strb(strb_wo), .dec_is_wr(is_wr),
        .dec_wr_data(wd), .dec_wr_biten(be), .ext_req(req_wo), .ext_req_is_wr(iw_wo),
        .ext_wr_data(wd_wo), .ext_wr_biten(be_wo), .ext_rd_ack(x_rd_ack),
        .ext_rd_data(x_rd_data), .ext_wr_ack(x_wr_ack), .is_external(ie_wo),
        .rsp_rd_ack(ra_wo), .rsp_rd_data(rd_wo), .rsp_wr_ack(wa_wo));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        strb0 = '0; strb_ro = '0; strb_wo = '0; is_wr = 1'b0;
        wd = '0; be = '0; x_rd_ack = 1'b0; x_wr_ack = 1'b0; x_rd_data = '0;
    endtask

    task automatic t_reset();
        strb0 = 2'b11; strb_wo = 2'b11; is_wr = 1'b1;
        wd = 32'hDEAD_BEEF; be = 32'hFFFF_0000;
        repeat (3) @(negedge clk);
        check("R8 req0 in reset", 64'(req0), 64'h0);
        check("R8 is_wr in reset", 64'(iw0), 64'h0);
        check("R8 wdata in reset", 64'(wd0), 64'h0);
        check("R8 biten in reset", 64'(be0), 64'h0);
        idle();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_rw_wide_write();
        @(negedge clk);
        strb0 = 2'b10; is_wr = 1'b1; wd = 32'h1234_5678; be = 32'h00FF_F00F;
        #2;
        check("R5 rw is_external on write", 64'(ie0), 64'h1);
        @(negedge clk);
        check("R1 R8 sub-word 1 strobe", 64'(req0), 64'h2);
        check("R8 write flag delayed", 64'(iw0), 64'h1);
        check("R4 write data passed", 64'(wd0), 64'h1234_5678);
        check("R4 bit enables passed", 64'(be0), 64'h00FF_F00F);
        strb0 = 2'b01; is_wr = 1'b0;
        #2;
        check("R5 rw is_external on read", 64'(ie0), 64'h1);
        @(negedge clk);
        check("R1 sub-word 0 read strobe", 64'(req0), 64'h1);
        strb0 = '0;
        #2;
        check("R5 no strobe no external", 64'(ie0), 64'h0);
        @(negedge clk);
        check("R8 strobe drops", 64'(req0), 64'h0);
        idle();
    endtask

    task automatic t_read_only();
        @(negedge clk);
        strb_ro = 1'b1; is_wr = 1'b1; wd = 32'hCAFE_0001; be = 32'hFFFF_FFFF;
        #2;
        check("R2 ro write strobe suppressed", 64'(req_ro), 64'h0);
        check("R5 ro write not external", 64'(ie_ro), 64'h0);
        check("R4 ro wdata zero", 64'(wd_ro), 64'h0);
        check("R4 ro biten zero", 64'(be_ro), 64'h0);
        @(negedge clk);
        is_wr = 1'b0;
        #2;
        check("R9 ro read strobe same cycle", 64'(req_ro), 64'h1);
        check("R9 ro write flag same cycle", 64'(iw_ro), 64'h0);
        check("R5 ro read external", 64'(ie_ro), 64'h1);
        @(negedge clk);
        idle();
    endtask

    task automatic t_write_only();
        @(negedge clk);
        strb_wo = 2'b11; is_wr = 1'b0;
        #2;
        check("R5 wo read not external", 64'(ie_wo), 64'h0);
        @(negedge clk);
        check("R3 wo read strobe suppressed", 64'(req_wo), 64'h0);
        strb_wo = 2'b01; is_wr = 1'b1; wd = 32'hA5A5_5A5A; be = 32'h0000_FFFF;
        #2;
        check("R5 wo write external", 64'(ie_wo), 64'h1);
        @(negedge clk);
        check("R3 wo write strobe passes", 64'(req_wo), 64'h1);
        check("R4 wo write data passes", 64'(wd_wo), 64'hA5A5_5A5A);
        idle();
    endtask

    task automatic t_acks_overlap();
        @(negedge clk);
        strb0 = 2'b11; strb_ro = 1'b1; strb_wo = 2'b10; is_wr = 1'b0;
        x_rd_ack = 1'b1; x_wr_ack = 1'b1; x_rd_data = 32'h0BAD_F00D;
        #2;
        check("R6 rw read ack", 64'(ra0), 64'h1);
        check("R6 rw read data", 64'(rd0), 64'h0BAD_F00D);
        check("R7 rw write ack", 64'(wa0), 64'h1);
        check("R6 ro read data", 64'(rd_ro), 64'h0BAD_F00D);
        check("R7 ro write ack ignored", 64'(wa_ro), 64'h0);
        check("R6 wo read ack ignored", 64'(ra_wo), 64'h0);
        check("R6 wo read data zero", 64'(rd_wo), 64'h0);
        check("R7 wo write ack", 64'(wa_wo), 64'h1);
        @(negedge clk);
        check("R8 new strobe despite ack", 64'(req0), 64'h3);
        check("R3 wo strobe still gated", 64'(req_wo), 64'h0);
        idle();
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        idle();
        t_reset();
        t_rw_wide_write();
        t_read_only();
        t_write_only();
        t_acks_overlap();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule